// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block computes the integer quotient of a dividend by a divisor, one quotient bit per clock. Each operation is either signed or unsigned, chosen by a select line that travels with the operands. Signed results are truncated toward zero. A caller raises `start` for one cycle while the unit is idle. The unit then holds `busy` high. When it finishes it pulses `done` together with the new `quotient`. `q_write` marks a quotient that should be written back.

A zero divisor is handled by a policy input sampled with the operands. With the policy off, the unit quietly returns zero. With it on, the unit raises a one-cycle `fault` pulse, keeps the previous quotient, does not write, and sets a sticky divide-by-zero cause bit. That bit stays set until the caller pulses `clr_dz`. The quotient is the only arithmetic result, and the unit has no flag outputs.

Top module: `intdiv_unit`

## Requirements
- R1: With `op_signed`=0, the quotient is floor(dividend / divisor), treating both as unsigned 32-bit values.
- R2: With `op_signed`=1, operands are two's complement. The quotient magnitude is |dividend| / |divisor| truncated toward zero, and the quotient is negative exactly when the operand signs differ.
- R3: A signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000, with `fault`=0 and `q_write`=1.
- R4: For a non-zero divisor, `busy` is high from the cycle after the accepting edge until `done` rises. `done` and `q_write` are high for exactly the one cycle that begins 33 clock edges after the accepting edge, and `busy` is low in that cycle.
- R5: For a zero divisor with `trap_en`=0, in the cycle after the accepting edge `done`=1, `q_write`=1, `quotient`=0 and `fault`=0, and `dz_sticky` keeps its value.
- R6: For a zero divisor with `trap_en`=1, in the cycle after the accepting edge `done`=1, `fault`=1 and `q_write`=0, the quotient keeps its previous value, and `dz_sticky` becomes 1. `fault` is low in the following cycle.
- R7: Once set, `dz_sticky` stays 1 until a cycle with `clr_dz`=1 clears it. If a trap and a clear fall in the same cycle, the trap wins and the bit stays 1.
- R8: A `start` pulse while `busy` is high is ignored, and the running operation finishes with its own operands.
- R9: After reset, `busy`, `done`, `q_write`, `fault` and `dz_sticky` are 0 and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op_signed | input | 1 | 1 = signed divide, 0 = unsigned |
| dividend | input | 32 | First operand |
| divisor | input | 32 | Second operand |
| trap_en | input | 1 | Zero-divisor policy: 1 = trap, 0 = return zero |
| clr_dz | input | 1 | Clears the sticky divide-by-zero bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| q_write | output | 1 | Quotient is valid for write-back |
| quotient | output | 32 | Result register |
| fault | output | 1 | One-cycle zero-divisor trap pulse |
| dz_sticky | output | 1 | Sticky divide-by-zero cause |

## Verification
A zero-divisor operation reports in the cycle right after the edge that took `start`. A non-zero divisor reports 33 edges later: 32 iteration edges plus one sign-fixup edge. The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done` appears. It expects that count to be exactly 1 or 34 and reads `quotient`, `q_write` and `fault` in that same half-cycle. Sticky-bit and ignored-start checks are also sampled on falling edges, one cycle after the edge that should have acted.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

endpackage

// File: rtl/intdiv_mag.sv
module intdiv_mag #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [W-1:0] value,
   input  logic         is_signed,
   output logic [W-1:0] mag,
   output logic         neg
);

   generate
      if (SIGNED_EN) begin : g_signed
         always_comb begin
            neg = is_signed & value[W-1];
            mag = neg ? (~value + {{(W-1){1'b0}}, 1'b1}) : value;
         end
      end else begin : g_unsigned
         logic unused_sel;
         always_comb begin
            unused_sel = is_signed;
            neg        = 1'b0;
            mag        = value;
         end
      end
   endgenerate

endmodule

// File: rtl/intdiv_step.sv
module intdiv_step #(
   parameter int W = 32
) (
   input  logic [W-1:0] rem_in,
   input  logic [W-1:0] q_in,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] rem_out,
   output logic [W-1:0] q_out
);

   logic [W:0] shifted;
   logic [W:0] trial;
   logic       fits;

   always_comb begin
      shifted = {rem_in, q_in[W-1]};
      trial   = shifted - {1'b0, dvs};
      fits    = ~trial[W];
      rem_out = fits ? trial[W-1:0] : shifted[W-1:0];
      q_out   = {q_in[W-2:0], fits};
   end

endmodule

// File: rtl/intdiv_ctrl.sv
module intdiv_ctrl
   import intdiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic dvs_zero,
   output logic accept,
   output logic take_zero,
   output logic step_en,
   output logic fix_en,
   output logic busy
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   div_state_e     state;
   logic [CW-1:0]  cnt;

   always_comb begin
      accept    = start && (state == ST_IDLE);
      take_zero = accept && dvs_zero;
      step_en   = (state == ST_RUN);
      fix_en    = (state == ST_FIX);
      busy      = (state != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (accept && !dvs_zero) state <= ST_RUN;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= ST_FIX;
            end
            ST_FIX:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_signed,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   input  logic         trap_en,
   input  logic         clr_dz,
   output logic         busy,
   output logic         done,
   output logic         q_write,
   output logic [W-1:0] quotient,
   output logic         fault,
   output logic         dz_sticky
);

   generate
      if (W < 2) begin : g_bad_width
         $error("intdiv_unit: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] a_mag, b_mag;
   logic         a_neg, b_neg;
   logic         dvs_zero;
   logic         accept, take_zero, step_en, fix_en;

   logic [W-1:0] rem_q, acc_q, dvs_q;
   logic         neg_q;
   logic [W-1:0] rem_n, acc_n;
   logic         trap_hit;

   assign dvs_zero = (divisor == '0);
   assign trap_hit = take_zero && trap_en;

   intdiv_mag #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mag_a (
      .value(dividend), .is_signed(op_signed), .mag(a_mag), .neg(a_neg)
   );

   intdiv_mag #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mag_b (
      .value(divisor), .is_signed(op_signed), .mag(b_mag), .neg(b_neg)
   );

   intdiv_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .dvs_zero(dvs_zero),
      .accept(accept), .take_zero(take_zero), .step_en(step_en),
      .fix_en(fix_en), .busy(busy)
   );

   intdiv_step #(.W(W)) u_step (
      .rem_in(rem_q), .q_in(acc_q), .dvs(dvs_q),
      .rem_out(rem_n), .q_out(acc_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         acc_q <= '0;
         dvs_q <= '0;
         neg_q <= 1'b0;
      end else if (accept) begin
         rem_q <= '0;
         acc_q <= a_mag;
         dvs_q <= b_mag;
         neg_q <= a_neg ^ b_neg;
      end else if (step_en) begin
         rem_q <= rem_n;
         acc_q <= acc_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quotient <= '0;
         done     <= 1'b0;
         q_write  <= 1'b0;
         fault    <= 1'b0;
      end else begin
         done    <= fix_en || take_zero;
         q_write <= fix_en || (take_zero && !trap_en);
         fault   <= trap_hit;
         if (fix_en)
            quotient <= neg_q ? (~acc_q + {{(W-1){1'b0}}, 1'b1}) : acc_q;
         else if (take_zero && !trap_en)
            quotient <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dz_sticky <= 1'b0;
      else if (trap_hit) dz_sticky <= 1'b1;
      else if (clr_dz)   dz_sticky <= 1'b0;
   end

endmodule

// File: rtl/intdiv_chk.sv
module intdiv_chk #(
   parameter int W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic clr_dz,
   input logic busy,
   input logic done,
   input logic q_write,
   input logic fault,
   input logic dz_sticky
);

   logic [7:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   // R6
   trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && !q_write));

   // R6
   trap_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> dz_sticky);

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dz_sticky && !clr_dz) |=> dz_sticky);

   // R7
   sticky_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dz_sticky) |-> $past(clr_dz));

   // R4
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(busy)) |-> (run_len == 8'(W + 1)));

endmodule

bind intdiv_unit intdiv_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_dz(clr_dz), .busy(busy), .done(done),
   .q_write(q_write), .fault(fault), .dz_sticky(dz_sticky)
);

// File: tb/sim_intdiv_unit.sv
`timescale 1ns/1ps
module sim_intdiv_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;

   // {signed, dividend, divisor, expected quotient}
   localparam logic [96:0] VEC [NV] = '{
      {1'b0, 32'd100,        32'd7,          32'd14},
      {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
      {1'b0, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF},
      {1'b0, 32'd5,          32'd9,          32'd0},
      {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
      {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
      {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9,   32'd14},
      {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
      {1'b1, 32'h80000000,   32'd2,          32'hC0000000},
      {1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0},
      {1'b1, 32'h000F4240,   32'd1000,       32'd1000},
      {1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, op_signed = 1'b0, trap_en = 1'b0, clr_dz = 1'b0;
   logic [31:0] dividend = '0, divisor = '0;
   logic        busy, done, q_write, fault, dz_sticky;
   logic [31:0] quotient;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intdiv_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
      .dividend(dividend), .divisor(divisor), .trap_en(trap_en),
      .clr_dz(clr_dz), .busy(busy), .done(done), .q_write(q_write),
      .quotient(quotient), .fault(fault), .dz_sticky(dz_sticky)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one operation; returns falling edges from the accepting edge to done.
   task automatic issue(input logic sg, input logic [31:0] a, input logic [31:0] b,
                        input logic te, output int lat);
      @(negedge clk);
      op_signed = sg; dividend = a; divisor = b; trap_en = te; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [31:0] prev_q;
      // R9 reset state
      repeat (3) @(negedge clk);
      chk({busy, done, q_write, fault, dz_sticky} == 5'b0, "R9 flags in reset",
          {27'd0, busy, done, q_write, fault, dz_sticky}, 32'd0);
      chk(quotient == 32'd0, "R9 quotient in reset", quotient, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, fault, dz_sticky} == 4'b0, "R9 flags after reset",
          {28'd0, busy, done, fault, dz_sticky}, 32'd0);

      // R1 R2 R3 vector table
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][96], VEC[i][95:64], VEC[i][63:32], 1'b0, lat);
         chk(lat == 34, VEC[i][96] ? "R2 R4 latency" : "R1 R4 latency",
             32'(lat), 32'd34);
         chk(quotient == VEC[i][31:0], VEC[i][96] ? "R2 R3 quotient" : "R1 quotient",
             quotient, VEC[i][31:0]);
         chk(q_write && !fault && !busy, "R3 R4 write no fault",
             {29'd0, q_write, fault, busy}, 32'd4);
         @(negedge clk);
         chk(!done && !q_write, "R4 done single cycle", {30'd0, done, q_write}, 32'd0);
      end

      // R4 busy during run
      @(negedge clk);
      op_signed = 1'b0; dividend = 32'd1234; divisor = 32'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done, "R4 busy after accept", {30'd0, busy, done}, 32'd2);
      // R8 start while busy ignored
      repeat (4) @(negedge clk);
      dividend = 32'd9; divisor = 32'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 6;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 34, "R8 latency unchanged", 32'(lat), 32'd34);
      chk(quotient == 32'd123, "R8 first operands kept", quotient, 32'd123);
      @(negedge clk);
      chk(!busy && !done, "R8 no second run", {30'd0, busy, done}, 32'd0);

      // R5 zero divisor, quiet policy
      issue(1'b1, 32'd55, 32'd0, 1'b0, lat);
      chk(lat == 1, "R5 latency", 32'(lat), 32'd1);
      chk(quotient == 32'd0 && q_write && !fault, "R5 zero result",
          quotient, 32'd0);
      chk(!dz_sticky, "R5 sticky untouched", {31'd0, dz_sticky}, 32'd0);

      // set a known quotient, then R6 trap
      issue(1'b0, 32'd77, 32'd7, 1'b0, lat);
      prev_q = quotient;
      issue(1'b0, 32'd5, 32'd0, 1'b1, lat);
      chk(lat == 1, "R6 latency", 32'(lat), 32'd1);
      chk(fault && done && !q_write, "R6 fault no write",
          {29'd0, fault, done, q_write}, 32'd6);
      chk(quotient == 32'd11 && prev_q == 32'd11, "R6 quotient kept", quotient, 32'd11);
      chk(dz_sticky, "R6 sticky set", {31'd0, dz_sticky}, 32'd1);
      @(negedge clk);
      chk(!fault, "R6 fault pulse", {31'd0, fault}, 32'd0);

      // R7 sticky holds through other work
      issue(1'b0, 32'd20, 32'd4, 1'b0, lat);
      chk(quotient == 32'd5, "R7 normal op after trap", quotient, 32'd5);
      issue(1'b0, 32'd20, 32'd0, 1'b0, lat);
      chk(dz_sticky, "R5 R7 quiet zero keeps sticky", {31'd0, dz_sticky}, 32'd1);
      repeat (5) @(negedge clk);
      chk(dz_sticky, "R7 sticky holds", {31'd0, dz_sticky}, 32'd1);
      clr_dz = 1'b1;
      @(negedge clk);
      clr_dz = 1'b0;
      chk(!dz_sticky, "R7 cleared", {31'd0, dz_sticky}, 32'd0);

      // R7 trap wins over clear in same cycle
      @(negedge clk);
      op_signed = 1'b1; dividend = 32'd3; divisor = 32'd0; trap_en = 1'b1;
      start = 1'b1; clr_dz = 1'b1;
      @(negedge clk);
      start = 1'b0; clr_dz = 1'b0; trap_en = 1'b0;
      chk(dz_sticky && fault, "R7 set wins over clear",
          {30'd0, dz_sticky, fault}, 32'd3);

      // R9 reset mid-run
      issue(1'b0, 32'd1, 32'd1, 1'b0, lat);
      @(negedge clk);
      start = 1'b1; dividend = 32'd50; divisor = 32'd5;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, dz_sticky} == 3'b0 && quotient == 32'd0, "R9 reset mid-run",
          quotient, 32'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule